// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave has left stuck, typically with SDA held low partway through a byte. When a start request arrives, the block looks at the synchronised SCL and SDA levels. If both are already high, the bus is idle and the block finishes in the next cycle without touching the bus. If either line is low, it pulls SCL low and releases it for a fixed number of clock pulses. This gives the slave enough clocks to shift out the rest of its byte and let go of SDA.

After the last pulse, the block watches the bus until both lines read high. It then reports completion. If the bus is still not idle when a bounded time has passed, it reports completion with an error. The block drives only SCL, through an open-drain style pull-low request, and it never drives SDA. All timing is given as microsecond and millisecond parameters, which the block converts into system-clock cycle counts using a clock-frequency parameter. Pin multiplexing, and the decision of when recovery is needed, belong to the surrounding logic.

Top module: `i2c_bus_clear`

## Requirements
- R1: If the synchronised SCL and SDA are both high when a start is accepted, `done_o` pulses in the cycle after the accepting edge, `err_o` is 0, and `scl_drive_low_o` stays 0.
- R2: Otherwise exactly PULSE_COUNT (default 9) separate pull-low intervals appear on `scl_drive_low_o`, and the first one begins in the cycle after the accepting edge.
- R3: Each pull-low interval and each release gap between two intervals lasts PHASE = CLK_HZ/1_000_000*PHASE_US cycles. After the last interval there is also a release of PHASE cycles before watching begins.
- R4: `scl_drive_low_o` (1 = pull SCL low) is 0 at all times outside the pulse phase: while idle, while watching for idle, and after completion. SDA is only an input.
- R5: While watching, the block completes with `done_o` = 1 and `err_o` = 0 on the first edge at which the synchronised lines are both high. Because of the two-flop input synchroniser, a release seen by the bench at sample k is reported at sample k+3, and never earlier than one cycle after watching begins.
- R6: If the bus is not idle within WAIT = CLK_HZ/1000*WAIT_MS cycles of watching, `done_o` pulses together with `err_o` = 1.
- R7: `done_o` is high for exactly one cycle. `err_o` holds its value until the next accepted start, which clears it.
- R8: A start request while a sequence is running is ignored. The pulse count, pulse timing and completion time do not change.
- R9: After reset, `scl_drive_low_o`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a recovery sequence; sampled only when idle |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Bus still busy at timeout; valid from done until next start |

## Verification
The assertions take for granted that `start_i` is synchronous to `clk`, and that the line inputs, though possibly asynchronous, have settled through the synchroniser before a start is judged. The bench therefore applies its stuck-line conditions three cycles before each start and changes every input only on the falling clock edge. It models the bus as wired-AND: SCL is low when either the block or an external holder pulls it. The bench then sweeps the moment the stuck lines are released across the pulse phase, the watch window and both sides of the timeout boundary.

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int PHASE_US    = 50,
  parameter int WAIT_MS     = 200,
  parameter int PULSE_COUNT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_low_o,
  output logic done_o,
  output logic err_o
);

  localparam int PHASE_CYC = CLK_HZ / 1_000_000 * PHASE_US;
  localparam int WAIT_CYC  = CLK_HZ / 1000 * WAIT_MS;
  localparam int PW = $clog2(PHASE_CYC + 1);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam int NW = $clog2(PULSE_COUNT + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYC - 1);
  localparam logic [WW-1:0] W_LAST  = WW'(WAIT_CYC - 1);
  localparam logic [NW-1:0] N_LAST  = NW'(PULSE_COUNT - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_WAIT} state_t;

  state_t        state;
  logic          scl_m, scl_s, sda_m, sda_s;
  logic [PW-1:0] ph_cnt;
  logic [WW-1:0] w_cnt;
  logic [NW-1:0] n_cnt;

  wire bus_idle  = scl_s & sda_s;
  wire phase_end = (ph_cnt == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m;
      sda_m <= sda_i; sda_s <= sda_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph_cnt <= '0;
      w_cnt  <= '0;
      n_cnt  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          err_o <= 1'b0;
          if (bus_idle) begin
            done_o <= 1'b1;
          end else begin
            state  <= S_LOW;
            ph_cnt <= '0;
            n_cnt  <= '0;
          end
        end
        S_LOW: begin
          if (phase_end) begin
            ph_cnt <= '0;
            state  <= S_HIGH;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (phase_end) begin
            ph_cnt <= '0;
            if (n_cnt == N_LAST) begin
              state <= S_WAIT;
              w_cnt <= '0;
            end else begin
              n_cnt <= n_cnt + 1'b1;
              state <= S_LOW;
            end
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (bus_idle) begin
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else if (w_cnt == W_LAST) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            state  <= S_IDLE;
          end else begin
            w_cnt <= w_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low_o = (state == S_LOW);

  logic          drive_q;
  logic [NW:0]   chk_pulses;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q    <= 1'b0;
      chk_pulses <= '0;
    end else begin
      drive_q <= scl_drive_low_o;
      if (done_o)
        chk_pulses <= '0;
      else if (scl_drive_low_o && !drive_q)
        chk_pulses <= chk_pulses + 1'b1;
    end
  end

  assert_idle_finish_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i && bus_idle) |=> (done_o && !err_o && !scl_drive_low_o));

  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chk_pulses) <= PULSE_COUNT);

  assert_no_drive_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !scl_drive_low_o);

  assert_wait_success_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && bus_idle) |=> (done_o && !err_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_only_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

endmodule

// File: tb/i2c_bus_clear_test.sv
`timescale 1ns/1ps
module i2c_bus_clear_test;
  localparam int CLK_HZ = 2_000_000;
  localparam int PHASE_US = 2;
  localparam int WAIT_MS = 1;
  localparam int NP = 9;
  localparam int P = CLK_HZ / 1_000_000 * PHASE_US;
  localparam int W = CLK_HZ / 1000 * WAIT_MS;
  localparam int PEND = 2 * P * NP;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic scl_hold = 1'b0, sda_hold = 1'b0;
  logic scl_i, sda_i, scl_drive_low_o, done_o, err_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  assign scl_i = !(scl_drive_low_o | scl_hold);
  assign sda_i = !sda_hold;

  i2c_bus_clear #(.CLK_HZ(CLK_HZ), .PHASE_US(PHASE_US), .WAIT_MS(WAIT_MS), .PULSE_COUNT(NP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_drive_low_o(scl_drive_low_o), .done_o(done_o), .err_o(err_o));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190_000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input bit hs, input bit hc, input int rel_k, input int again_k);
    int exp_k, exp_p, done_k, pulses, bad_w, bad_d, seg;
    bit exp_err, e, d, prev;
    string req;
    if (!hs && !hc) begin
      exp_k = 0; exp_err = 0; exp_p = 0; req = "R1";
    end else if (rel_k >= 0 && rel_k + 3 <= PEND + W) begin
      exp_k = (rel_k + 3 > PEND + 1) ? rel_k + 3 : PEND + 1;
      exp_err = 0; exp_p = NP; req = "R5";
    end else begin
      exp_k = PEND + W; exp_err = 1; exp_p = NP; req = "R6";
    end
    @(negedge clk);
    sda_hold = hs; scl_hold = hc;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    done_k = -1; pulses = 0; bad_w = 0; bad_d = 0; seg = 0; prev = 0; e = 0;
    for (int k = 0; k < PEND + W + 20; k++) begin
      if (k > 0) @(negedge clk);
      start_i = (k == again_k);
      d = scl_drive_low_o;
      if (k == 0) check(err_o == 1'b0, "R7", "err cleared at start", err_o, 0);
      if (d != prev) begin
        if (d) begin
          pulses++;
          if (pulses > 1 && seg != P) bad_w++;
        end else if (seg != P) bad_w++;
        seg = 0;
      end
      seg++;
      if (k >= PEND && d) bad_d++;
      if (done_o) begin
        done_k = k; e = err_o;
        break;
      end
      if (k == rel_k) begin
        sda_hold = 1'b0; scl_hold = 1'b0;
      end
      prev = d;
    end
    start_i = 1'b0;
    check(done_k == exp_k, req, "done sample", done_k, exp_k);
    check(e == exp_err, "R6", "err at done", e, exp_err);
    check(pulses == exp_p, (again_k >= 0) ? "R8" : "R2", "pulse count", pulses, exp_p);
    check(bad_w == 0, "R3", "bad phase widths", bad_w, 0);
    check(bad_d == 0, "R4", "drive outside pulses", bad_d, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
    check(err_o == exp_err, "R7", "err held", err_o, exp_err);
    check(scl_drive_low_o == 1'b0, "R4", "drive after done", scl_drive_low_o, 0);
    sda_hold = 1'b0; scl_hold = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_drive_low_o == 0 && done_o == 0 && err_o == 0, "R9", "reset outputs",
          {scl_drive_low_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_drive_low_o == 0 && done_o == 0 && err_o == 0, "R9", "after reset",
          {scl_drive_low_o, done_o, err_o}, 0);
    run(0, 0, -1, -1);
    for (int r = 0; r <= PEND + 60; r += 3) run(1, 0, r, -1);
    run(1, 0, -1, -1);
    run(0, 0, -1, -1);
    run(0, 1, -1, -1);
    run(1, 1, 10, -1);
    run(1, 0, PEND + W - 3, -1);
    run(1, 0, PEND + W - 2, -1);
    run(1, 0, 5, 10);
    run(1, 0, PEND + 30, PEND + 5);
    run(1, 0, -1, 3 * P + 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule